// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment-and-offset pair into a 20-bit physical address. The segment's 16-bit value is shifted left by four bits to form a base, and the offset is added to it. The sum wraps within the 1 MB physical space, which runs from 00000h to FFFFFh. The caller supplies the current contents of all six segment registers, the offset, and a code that names the base register (or literal) the offset came from. The block uses that code to pick the default segment. An optional override, qualified by its own valid bit, can replace the default.

An offset wider than 16 bits cannot be used in real mode. The block flags such an offset as a fault and returns a zero address in its place. Results come out of one registered stage with valid/ready handshaking: one cycle of latency, and the result is held while the consumer stalls.

Top module: `seg_addr_unit`

## Requirements
- R1: While reset is asserted and after it, until the first accepted request: `out_valid` is 0 and `in_ready` is 1.
- R2: The physical address is (segment << 4) + offset[15:0], modulo 2^20. For example, 1000h:F000h gives 1F000h and FFFFh:0010h gives 00000h.
- R3: Selector code 9 (instruction pointer) always uses CS (index 1), even when a valid override is present.
- R4: With no usable override, selector codes 4 (SP) and 5 (BP) use SS (index 2).
- R5: With no usable override, selector codes 0–3 (AX, BX, CX, DX), 6 (SI), 7 (DI), 8 (literal displacement) and 11–15 use DS (index 3).
- R6: With no usable override, selector code 10 (string destination through DI) uses ES (index 0).
- R7: When `ovr_valid` is 1 and `ovr_seg` is 0–5, the override index replaces the default for every selector except 9. This is the only way to reach FS (index 4) and GS (index 5). Override codes 6 and 7 are ignored.
- R8: An offset above FFFFh sets `out_fault` to 1 and forces `out_addr` to 0. `out_seg` still reports the chosen segment.
- R9: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` = 1 right after that edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_addr`, `out_seg` and `out_fault` hold their values, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| seg_es | input | 16 | ES value (index 0) |
| seg_cs | input | 16 | CS value (index 1) |
| seg_ss | input | 16 | SS value (index 2) |
| seg_ds | input | 16 | DS value (index 3) |
| seg_fs | input | 16 | FS value (index 4) |
| seg_gs | input | 16 | GS value (index 5) |
| in_off | input | 32 | Offset |
| in_sel | input | 4 | Base-register selector code |
| ovr_valid | input | 1 | Override valid |
| ovr_seg | input | 3 | Override segment index |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 20 | Physical address, or 0 on fault |
| out_seg | output | 3 | Index of the segment used |
| out_fault | output | 1 | Offset exceeded FFFFh |

## Verification
Every result is due one clock edge after its acceptance. `in_ready` is combinational and reflects the current `out_ready` within the same cycle. The bench drives inputs at the falling edge. After a short settle it checks `in_ready`. It then checks `out_valid`, `out_addr`, `out_seg` and `out_fault` at the next falling edge against a one-entry model. That model is loaded only on an edge where it predicts acceptance, and it is cleared when the output is consumed. During stalls the segment values and offset are re-randomised, so the same comparison also confirms that held results do not follow the inputs.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 6;
  localparam int IDX_W   = 3;
  localparam int SEL_W   = 4;

  typedef enum logic [IDX_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_idx_e;

  typedef enum logic [SEL_W-1:0] {
    BR_AX   = 4'd0,
    BR_BX   = 4'd1,
    BR_CX   = 4'd2,
    BR_DX   = 4'd3,
    BR_SP   = 4'd4,
    BR_BP   = 4'd5,
    BR_SI   = 4'd6,
    BR_DI   = 4'd7,
    BR_LIT  = 4'd8,
    BR_IP   = 4'd9,
    BR_SDST = 4'd10
  } base_sel_e;
endpackage

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             ovr_valid,
  input  logic [IDX_W-1:0] ovr_seg,
  output logic [IDX_W-1:0] seg_idx
);
  logic [IDX_W-1:0] dflt_idx;
  logic             ovr_ok;

  always_comb begin
    case (sel)
      BR_SP, BR_BP: dflt_idx = SEG_SS;
      BR_SDST:      dflt_idx = SEG_ES;
      BR_IP:        dflt_idx = SEG_CS;
      default:      dflt_idx = SEG_DS;
    endcase
  end

  assign ovr_ok = ovr_valid && (ovr_seg < IDX_W'(NUM_SEG));

  always_comb begin
    if (sel == BR_IP)  seg_idx = SEG_CS;
    else if (ovr_ok)   seg_idx = ovr_seg;
    else               seg_idx = dflt_idx;
  end
endmodule

// File: rtl/seg_phys_add.sv
module seg_phys_add #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 32,
  parameter int LIM_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  addr,
  output logic             fault
);
  localparam int BASE_W = SEG_W + SHIFT;

  logic [BASE_W-1:0] base;
  logic [PA_W-1:0]   base_pa;
  logic [PA_W-1:0]   off_pa;

  assign base    = {seg_val, {SHIFT{1'b0}}};
  assign base_pa = base[PA_W-1:0];
  assign off_pa  = {{(PA_W-LIM_W){1'b0}}, off[LIM_W-1:0]};

  generate
    if (OFF_W > LIM_W) begin : g_range_chk
      assign fault = |off[OFF_W-1:LIM_W];
    end else begin : g_no_chk
      assign fault = 1'b0;
    end
  endgenerate

  assign addr = fault ? '0 : (base_pa + off_pa);
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int PA_W  = 20,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PA_W-1:0]  d_addr,
  input  logic [IDX_W-1:0] d_seg,
  input  logic             d_fault,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  q_addr,
  output logic [IDX_W-1:0] q_seg,
  output logic             q_fault
);
  logic load_en;
  logic valid_nxt;

  assign in_ready = !out_valid || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    valid_nxt = out_valid;
    if (load_en)        valid_nxt = 1'b1;
    else if (out_ready) valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_seg   <= '0;
      q_fault <= 1'b0;
    end else if (load_en) begin
      q_addr  <= d_addr;
      q_seg   <= d_seg;
      q_fault <= d_fault;
    end
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 32,
  parameter int LIM_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  input  logic [SEG_W-1:0] seg_fs,
  input  logic [SEG_W-1:0] seg_gs,
  input  logic [OFF_W-1:0] in_off,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             ovr_valid,
  input  logic [IDX_W-1:0] ovr_seg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  out_addr,
  output logic [IDX_W-1:0] out_seg,
  output logic             out_fault
);
  logic [SEG_W-1:0] bank [NUM_SEG];
  logic [IDX_W-1:0] pick_idx;
  logic [SEG_W-1:0] pick_val;
  logic [PA_W-1:0]  sum_addr;
  logic             sum_fault;

  assign bank[SEG_ES] = seg_es;
  assign bank[SEG_CS] = seg_cs;
  assign bank[SEG_SS] = seg_ss;
  assign bank[SEG_DS] = seg_ds;
  assign bank[SEG_FS] = seg_fs;
  assign bank[SEG_GS] = seg_gs;

  seg_select u_sel (
    .sel       (in_sel),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .seg_idx   (pick_idx)
  );

  always_comb begin
    pick_val = bank[SEG_DS];
    for (int i = 0; i < NUM_SEG; i++) begin
      if (pick_idx == IDX_W'(i)) pick_val = bank[i];
    end
  end

  seg_phys_add #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .LIM_W (LIM_W),
    .SHIFT (SHIFT),
    .PA_W  (PA_W)
  ) u_add (
    .seg_val (pick_val),
    .off     (in_off),
    .addr    (sum_addr),
    .fault   (sum_fault)
  );

  seg_out_stage #(
    .PA_W  (PA_W),
    .IDX_W (IDX_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_addr    (sum_addr),
    .d_seg     (pick_idx),
    .d_fault   (sum_fault),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_addr    (out_addr),
    .q_seg     (out_seg),
    .q_fault   (out_fault)
  );
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk
  import seg_pkg::*;
#(
  parameter int PA_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SEL_W-1:0] in_sel,
  input logic             ovr_valid,
  input logic [IDX_W-1:0] ovr_seg,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PA_W-1:0]  out_addr,
  input logic [IDX_W-1:0] out_seg,
  input logic             out_fault
);
  logic take;
  logic ovr_used;
  assign take     = in_valid && in_ready;
  assign ovr_used = ovr_valid && (ovr_seg < IDX_W'(NUM_SEG));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_seg) && $stable(out_fault));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> out_addr == '0);

  p_ip_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_sel == BR_IP |=> out_seg == SEG_CS);

  p_stack_ss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !ovr_used && (in_sel == BR_SP || in_sel == BR_BP) |=> out_seg == SEG_SS);

  p_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && ovr_used && in_sel != BR_IP |=> out_seg == $past(ovr_seg));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_seg < IDX_W'(NUM_SEG));
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sel    (in_sel),
  .ovr_valid (ovr_valid),
  .ovr_seg   (ovr_seg),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_seg   (out_seg),
  .out_fault (out_fault)
);

// File: tb/seg_addr_unit_test.sv
module seg_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, ovr_valid, out_valid, out_ready, out_fault;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds, seg_fs, seg_gs;
  logic [31:0] in_off;
  logic [3:0]  in_sel;
  logic [2:0]  ovr_seg, out_seg;
  logic [19:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;

  bit          m_valid = 1'b0;
  logic [19:0] m_addr;
  logic [2:0]  m_seg;
  bit          m_fault;
  string       m_tag = "R2";

  always #5 clk = ~clk;

  seg_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_fs(seg_fs), .seg_gs(seg_gs), .in_off(in_off), .in_sel(in_sel),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_seg(out_seg),
    .out_fault(out_fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_seg(input logic [3:0] sel, input bit ov,
                                         input logic [2:0] os);
    if (sel == 4'd9) return 3'd1;
    if (ov && os <= 3'd5) return os;
    if (sel == 4'd4 || sel == 4'd5) return 3'd2;
    if (sel == 4'd10) return 3'd0;
    return 3'd3;
  endfunction

  function automatic logic [15:0] seg_of(input logic [2:0] idx);
    case (idx)
      3'd0: return seg_es;
      3'd1: return seg_cs;
      3'd2: return seg_ss;
      3'd3: return seg_ds;
      3'd4: return seg_fs;
      default: return seg_gs;
    endcase
  endfunction

  function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [31:0] o);
    if (o > 32'h0000_FFFF) return 20'h0;
    return 20'({s, 4'h0} + {4'h0, o[15:0]});
  endfunction

  function automatic string tag_of(input logic [3:0] sel, input bit ov,
                                   input logic [2:0] os);
    if (sel == 4'd9) return "R3";
    if (ov && os <= 3'd5) return "R7";
    if (sel == 4'd4 || sel == 4'd5) return "R4";
    if (sel == 4'd10) return "R6";
    return "R5";
  endfunction

  // Called at a falling edge; drives one cycle and checks the result after the next edge.
  task automatic step(input bit v, input logic [3:0] sel, input logic [31:0] off,
                      input bit ov, input logic [2:0] os, input bit ordy);
    bit exp_rdy;
    bit take;
    logic [2:0] si;
    in_valid = v; in_sel = sel; in_off = off;
    ovr_valid = ov; ovr_seg = os; out_ready = ordy;
    #1;
    exp_rdy = !m_valid || ordy;
    chk(in_ready == exp_rdy, "R10", "in_ready", 32'(in_ready), 32'(exp_rdy));
    take = v && exp_rdy;
    if (take) begin
      si      = exp_seg(sel, ov, os);
      m_seg   = si;
      m_addr  = exp_addr(seg_of(si), off);
      m_fault = off > 32'h0000_FFFF;
      m_tag   = tag_of(sel, ov, os);
      m_valid = 1'b1;
    end else if (ordy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == m_valid, "R9", "out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid && out_valid) begin
      chk(out_seg == m_seg, m_tag, "out_seg", 32'(out_seg), 32'(m_seg));
      chk(out_fault == m_fault, "R8", "out_fault", 32'(out_fault), 32'(m_fault));
      chk(out_addr == m_addr, m_fault ? "R8" : "R2", "out_addr",
          32'(out_addr), 32'(m_addr));
    end
  endtask

  task automatic rand_segs();
    seg_es = 16'($urandom); seg_cs = 16'($urandom); seg_ss = 16'($urandom);
    seg_ds = 16'($urandom); seg_fs = 16'($urandom); seg_gs = 16'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_sel = 4'd0;
    in_off = '0; ovr_valid = 1'b0; ovr_seg = 3'd0;
    rand_segs();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);

    // Directed corner cases
    seg_ds = 16'h1000;
    step(1, 4'd1, 32'h0000_F000, 0, 3'd0, 1);               // R2: 1F000
    chk(out_addr == 20'h1F000, "R2", "1000:F000", 32'(out_addr), 32'h1F000);
    seg_ds = 16'hFFFF;
    step(1, 4'd8, 32'h0000_0010, 0, 3'd0, 1);               // R2 wrap
    chk(out_addr == 20'h00000, "R2", "FFFF:0010", 32'(out_addr), 32'h0);
    step(1, 4'd9, 32'h0000_1234, 1, 3'd4, 1);               // R3: override ignored
    step(1, 4'd5, 32'h0000_0002, 0, 3'd0, 1);               // R4
    step(1, 4'd10, 32'h0000_0100, 0, 3'd0, 1);              // R6
    step(1, 4'd6, 32'h0000_0100, 1, 3'd5, 1);               // R7 GS
    step(1, 4'd4, 32'h0000_0100, 1, 3'd7, 1);               // R7 illegal override -> SS
    step(1, 4'd2, 32'h0001_0000, 0, 3'd0, 1);               // R8 fault
    chk(out_fault == 1'b1, "R8", "fault flag", 32'(out_fault), 32'd1);
    step(1, 4'd3, 32'h0000_0040, 0, 3'd0, 0);               // R10 stall start
    rand_segs();
    step(1, 4'd3, 32'h0000_0080, 0, 3'd0, 0);               // R10 held
    step(0, 4'd0, 32'h0, 0, 3'd0, 1);
    step(0, 4'd0, 32'h0, 0, 3'd0, 1);

    // Constrained random phase
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] off;
      rand_segs();
      off = ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 16'hFFFF));
      step($urandom_range(0, 3) != 0, 4'($urandom), off,
           $urandom_range(0, 2) == 0, 3'($urandom), $urandom_range(0, 3) != 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule